// File: doc/BRIEF.md
# Endpoint Interrupt Flag Controller

This block gathers the event pulses of a set of data endpoints, numbered 1 to `NUM_EP`, into two sticky flag registers. The IN register collects transmit-side events and the OUT register collects receive-side events. Bit x of each register belongs to endpoint x. The CPU reads the flags and clears them by writing ones.

Each endpoint has an enable bit per direction. The enable bit does not stop the endpoint flag from latching. An event on an enabled endpoint also latches a single shared CPU flag, which the CPU clears on its own. An interrupt request is raised while the global enable is high and at least one latched flag has its enable bit set.

Endpoints marked isochronous cannot be stalled, so the block drops their stall pulses.

Top module: `eif_ctrl`

## Requirements
- R1: For endpoint x from 1 to NUM_EP, a pulse on `in_sent[x]`, `in_flush[x]` or `in_stall[x]` sets `in_flags[x]` at the next clock edge, whatever the value of `in_en[x]`.
- R2: For endpoint x from 1 to NUM_EP, a pulse on `out_rcvd[x]` or `out_stall[x]` sets `out_flags[x]` at the next clock edge, whatever the value of `out_en[x]`.
- R3: While `iso[x]` is 1, the stall inputs `in_stall[x]` and `out_stall[x]` are ignored. They set neither an endpoint flag nor `cpu_flag`.
- R4: Writing 1 to bit x of `clr_in` or `clr_out` clears that flag at the next edge. Bits written 0 leave their flags unchanged.
- R5: If an event and a clear reach the same flag in the same cycle, the flag ends up set.
- R6: `cpu_flag` sets at the next edge when an accepted event occurs on an endpoint whose enable bit for that direction is 1. An event on a masked endpoint leaves it unchanged.
- R7: `clr_cpu` clears `cpu_flag` at the next edge. An accepted unmasked event in the same cycle keeps it set. Clearing endpoint flags does not affect `cpu_flag`.
- R8: `irq_req` is high exactly when `glob_en` is 1 and some bit x has `in_flags[x]&in_en[x]` or `out_flags[x]&out_en[x]` set. It is combinational from the flags and the enables.
- R9: Bit 0 and all bits above NUM_EP of both flag registers always read 0. Events on those bits are ignored.
- R10: After a synchronous active-low reset, both flag registers and `cpu_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sent | input | 8 | Per-endpoint pulse: an IN packet went to the host |
| in_stall | input | 8 | Per-endpoint pulse: a stall handshake was sent on IN |
| in_flush | input | 8 | Per-endpoint pulse: the IN buffer was flushed |
| out_rcvd | input | 8 | Per-endpoint pulse: an OUT packet was received |
| out_stall | input | 8 | Per-endpoint pulse: a stall handshake was sent on OUT |
| iso | input | 8 | Per-endpoint isochronous configuration (1 = stalls ignored) |
| in_en | input | 8 | Per-endpoint IN interrupt enable |
| out_en | input | 8 | Per-endpoint OUT interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| clr_in | input | 8 | Write-one-to-clear strobe for IN flags |
| clr_out | input | 8 | Write-one-to-clear strobe for OUT flags |
| clr_cpu | input | 1 | Clear strobe for the shared CPU flag |
| in_flags | output | 8 | IN flag register |
| out_flags | output | 8 | OUT flag register |
| cpu_flag | output | 1 | Shared CPU interrupt flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is 0 while reset is held. This keeps the `$past`-based set and clear properties from referring to values from before reset. They also assume that the clear strobes and event pulses are held for whole cycles.

The bench meets both assumptions. It drives all inputs at the falling edge and holds them at zero through reset. It then sweeps every bit position (including bits 0, 6 and 7), every event kind, both enable values and both isochronous settings. After that it runs pseudo-random mixes of events, clears and enables against an arithmetic reference.

// File: rtl/eif_pkg.sv
// Package: register width shared by all endpoint interrupt flag modules.
// Assumes flag registers are one byte wide, with bit x for endpoint x.
package eif_pkg;
    localparam int EIF_REG_W = 8;

    // Accepted events for one cycle, in both directions.
    typedef struct packed {
        logic [EIF_REG_W-1:0] in_set;
        logic [EIF_REG_W-1:0] out_set;
    } eif_events_t;
endpackage

// File: rtl/eif_event_filter.sv
// Module: merges raw endpoint event pulses into per-direction set vectors.
// It drops stall pulses on isochronous endpoints and masks bits that
// correspond to no endpoint (bit 0 and every bit above NUM_EP).
// Assumes the pulses are already synchronous to clk.
module eif_event_filter
    import eif_pkg::*;
#(
    parameter int NUM_EP = 5
) (
    input  logic [EIF_REG_W-1:0] in_sent,
    input  logic [EIF_REG_W-1:0] in_stall,
    input  logic [EIF_REG_W-1:0] in_flush,
    input  logic [EIF_REG_W-1:0] out_rcvd,
    input  logic [EIF_REG_W-1:0] out_stall,
    input  logic [EIF_REG_W-1:0] iso,
    output eif_events_t          ev
);
    localparam logic [EIF_REG_W-1:0] ALL_UP = EIF_REG_W'((1 << (NUM_EP + 1)) - 1);
    localparam logic [EIF_REG_W-1:0] VALID  = ALL_UP & ~EIF_REG_W'(1);

    logic [EIF_REG_W-1:0] in_raw;
    logic [EIF_REG_W-1:0] out_raw;

    genvar b;
    generate
        for (b = 0; b < EIF_REG_W; b++) begin : g_bit
            // Per-bit merge: a stall counts only on a non-isochronous endpoint.
            always_comb begin
                in_raw[b]  = in_sent[b] | in_flush[b] | (in_stall[b] & ~iso[b]);
                out_raw[b] = out_rcvd[b] | (out_stall[b] & ~iso[b]);
            end
        end
    endgenerate

    // Keep only the bits that map to real endpoints.
    always_comb begin
        ev.in_set  = in_raw & VALID;
        ev.out_set = out_raw & VALID;
    end
endmodule

// File: rtl/eif_flag_reg.sv
// Module: sticky flag register with write-one-to-clear access.
// A set and a clear on the same bit in the same cycle leave the bit set.
// Assumes set bits outside the valid endpoint range are already masked.
module eif_flag_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_flag
            // One sticky bit: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)      q[b] <= 1'b0;
                else if (set[b]) q[b] <= 1'b1;
                else if (clr[b]) q[b] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/eif_cpu_flag.sv
// Module: shared CPU interrupt flag. It latches on any accepted event whose
// endpoint has its enable set for that direction, and is cleared only by
// its own strobe. Assumes the events come from eif_event_filter.
module eif_cpu_flag
    import eif_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  eif_events_t          ev,
    input  logic [EIF_REG_W-1:0] in_en,
    input  logic [EIF_REG_W-1:0] out_en,
    input  logic                 clr,
    output logic                 flag
);
    logic hit;

    // Detect any event that passes its endpoint's enable.
    always_comb hit = |((ev.in_set & in_en) | (ev.out_set & out_en));

    // Sticky flag: a new hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/eif_ctrl.sv
// Module: endpoint interrupt flag controller top.
// Collects IN and OUT endpoint events into sticky registers and drives a
// shared CPU flag plus an interrupt request that is gated by the global
// enable and the per-endpoint enables. Assumes a single clock domain.
module eif_ctrl
    import eif_pkg::*;
#(
    parameter int NUM_EP = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EIF_REG_W-1:0] in_sent,
    input  logic [EIF_REG_W-1:0] in_stall,
    input  logic [EIF_REG_W-1:0] in_flush,
    input  logic [EIF_REG_W-1:0] out_rcvd,
    input  logic [EIF_REG_W-1:0] out_stall,
    input  logic [EIF_REG_W-1:0] iso,
    input  logic [EIF_REG_W-1:0] in_en,
    input  logic [EIF_REG_W-1:0] out_en,
    input  logic                 glob_en,
    input  logic [EIF_REG_W-1:0] clr_in,
    input  logic [EIF_REG_W-1:0] clr_out,
    input  logic                 clr_cpu,
    output logic [EIF_REG_W-1:0] in_flags,
    output logic [EIF_REG_W-1:0] out_flags,
    output logic                 cpu_flag,
    output logic                 irq_req
);
    eif_events_t ev;

    eif_event_filter #(.NUM_EP(NUM_EP)) u_filter (
        .in_sent   (in_sent),
        .in_stall  (in_stall),
        .in_flush  (in_flush),
        .out_rcvd  (out_rcvd),
        .out_stall (out_stall),
        .iso       (iso),
        .ev        (ev)
    );

    eif_flag_reg #(.W(EIF_REG_W)) u_in_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev.in_set),
        .clr   (clr_in),
        .q     (in_flags)
    );

    eif_flag_reg #(.W(EIF_REG_W)) u_out_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev.out_set),
        .clr   (clr_out),
        .q     (out_flags)
    );

    eif_cpu_flag u_cpu (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .in_en  (in_en),
        .out_en (out_en),
        .clr    (clr_cpu),
        .flag   (cpu_flag)
    );

    // Request: global enable AND any latched flag whose enable is set.
    always_comb irq_req = glob_en & |((in_flags & in_en) | (out_flags & out_en));
endmodule

// File: rtl/eif_ctrl_chk.sv
// Checker: temporal properties of eif_ctrl, bound to every instance.
// Assumes all inputs are held at 0 while rst_n is low.
module eif_ctrl_chk
    import eif_pkg::*;
#(
    parameter int NUM_EP = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [EIF_REG_W-1:0] in_sent,
    input logic [EIF_REG_W-1:0] in_stall,
    input logic [EIF_REG_W-1:0] in_flush,
    input logic [EIF_REG_W-1:0] out_rcvd,
    input logic [EIF_REG_W-1:0] out_stall,
    input logic [EIF_REG_W-1:0] iso,
    input logic [EIF_REG_W-1:0] in_en,
    input logic [EIF_REG_W-1:0] out_en,
    input logic                 glob_en,
    input logic [EIF_REG_W-1:0] clr_in,
    input logic [EIF_REG_W-1:0] clr_out,
    input logic                 clr_cpu,
    input logic [EIF_REG_W-1:0] in_flags,
    input logic [EIF_REG_W-1:0] out_flags,
    input logic                 cpu_flag,
    input logic                 irq_req
);
    localparam logic [EIF_REG_W-1:0] VM =
        EIF_REG_W'((1 << (NUM_EP + 1)) - 1) & ~EIF_REG_W'(1);

    logic [EIF_REG_W-1:0] in_any, out_any, in_ok, out_ok;
    always_comb begin
        in_any  = in_sent | in_flush | in_stall;
        out_any = out_rcvd | out_stall;
        in_ok   = (in_sent | in_flush | (in_stall & ~iso)) & VM;
        out_ok  = (out_rcvd | (out_stall & ~iso)) & VM;
    end

    // R1
    in_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_sent & VM) != 0) |=> ((in_flags & $past(in_sent & VM)) == $past(in_sent & VM)));
    // R2
    out_rcvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_rcvd & VM) != 0) |=> ((out_flags & $past(out_rcvd & VM)) == $past(out_rcvd & VM)));
    // R4
    in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_in & ~in_any) != 0) |=> ((in_flags & $past(clr_in & ~in_any)) == 0));
    // R4
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_out & ~out_any) != 0) |=> ((out_flags & $past(clr_out & ~out_any)) == 0));
    // R9
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_flags & ~VM) == 0) && ((out_flags & ~VM) == 0));
    // R6
    cpu_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_flag) |-> $past(((in_ok & in_en) | (out_ok & out_en)) != 0));
    // R7
    cpu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cpu && ((in_ok & in_en) == 0) && ((out_ok & out_en) == 0)) |=> !cpu_flag);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glob_en);
endmodule

bind eif_ctrl eif_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/eif_ctrl_bench.sv
// Bench: bit-position and event-kind sweep plus a pseudo-random mix,
// compared against an arithmetic reference of the requirements.
module eif_ctrl_bench;
    localparam int NEP = 5;
    localparam logic [7:0] VM = 8'(((1 << (NEP + 1)) - 1) & ~1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] in_sent = '0, in_stall = '0, in_flush = '0, out_rcvd = '0, out_stall = '0;
    logic [7:0] iso = '0, in_en = '0, out_en = '0, clr_in = '0, clr_out = '0;
    logic glob_en = 1'b0, clr_cpu = 1'b0;
    logic [7:0] in_flags, out_flags;
    logic cpu_flag, irq_req;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_in = '0, m_out = '0;
    logic m_cpu = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    eif_ctrl #(.NUM_EP(NEP)) u_eif_ctrl (.*);

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic zero_ev();
        in_sent = '0; in_stall = '0; in_flush = '0; out_rcvd = '0; out_stall = '0;
        clr_in = '0; clr_out = '0; clr_cpu = 1'b0;
    endtask

    // One clock: update the reference, wait for the edge, compare away from it.
    task automatic step();
        logic [7:0] iset, oset;
        iset = (in_sent | in_flush | (in_stall & ~iso)) & VM;
        oset = (out_rcvd | (out_stall & ~iso)) & VM;
        m_in  = (m_in & ~clr_in) | iset;
        m_out = (m_out & ~clr_out) | oset;
        m_cpu = (m_cpu & ~clr_cpu) | (|((iset & in_en) | (oset & out_en)));
        @(posedge clk);
        @(negedge clk);
        chk(in_flags, m_in, "R1 in_flags");
        chk(out_flags, m_out, "R2 out_flags");
        chk({7'd0, cpu_flag}, {7'd0, m_cpu}, "R6 cpu_flag");
        chk({7'd0, irq_req}, {7'd0, glob_en & (|((m_in & in_en) | (m_out & out_en)))}, "R8 irq_req");
    endtask

    task automatic clear_all();
        zero_ev();
        clr_in = '1; clr_out = '1; clr_cpu = 1'b1;
        step();
        zero_ev();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(in_flags, 8'h00, "R10 in_flags after reset");
        chk(out_flags, 8'h00, "R10 out_flags after reset");
        chk({7'd0, cpu_flag}, 8'h00, "R10 cpu_flag after reset");

        // Sweep: every bit, event kind, enable value and isochronous setting.
        for (int bit_i = 0; bit_i < 8; bit_i++)
            for (int kind = 0; kind < 5; kind++)
                for (int cfg = 0; cfg < 4; cfg++) begin
                    clear_all();
                    glob_en = 1'b1;
                    in_en  = cfg[0] ? 8'hFF : 8'h00;
                    out_en = cfg[0] ? 8'hFF : 8'h00;
                    iso    = cfg[1] ? 8'hFF : 8'h00;
                    case (kind)
                        0: in_sent[bit_i]   = 1'b1;
                        1: in_stall[bit_i]  = 1'b1;
                        2: in_flush[bit_i]  = 1'b1;
                        3: out_rcvd[bit_i]  = 1'b1;
                        default: out_stall[bit_i] = 1'b1;
                    endcase
                    step();
                end

        // R3 isochronous stall ignored at the ports
        clear_all();
        iso = 8'hFF; in_en = 8'hFF; out_en = 8'hFF;
        in_stall = 8'hFF; out_stall = 8'hFF;
        step();
        chk(in_flags | out_flags, 8'h00, "R3 iso stalls ignored");
        chk({7'd0, cpu_flag}, 8'h00, "R3 iso stall no cpu flag");

        // R9 events on unused bits
        clear_all();
        iso = 8'h00; in_sent = 8'hC1; out_rcvd = 8'hC1;
        step();
        chk(in_flags | out_flags, 8'h00, "R9 unused bits stay 0");

        // R4 selective clear
        clear_all();
        in_sent = VM; out_rcvd = VM; step(); zero_ev();
        clr_in = 8'h04; clr_out = 8'h08; step();
        chk(in_flags, VM & ~8'h04, "R4 in selective clear");
        chk(out_flags, VM & ~8'h08, "R4 out selective clear");

        // R5 event and clear same cycle
        zero_ev();
        clr_in = 8'h02; in_flush = 8'h02; clr_out = 8'h20; out_stall = 8'h20;
        step();
        chk(in_flags & 8'h02, 8'h02, "R5 in set wins");
        chk(out_flags & 8'h20, 8'h20, "R5 out set wins");

        // R7 shared flag clearing
        clear_all();
        in_en = 8'h02; in_sent = 8'h02; step(); zero_ev();
        clr_in = 8'hFF; step();
        chk({7'd0, cpu_flag}, 8'h01, "R7 endpoint clear keeps cpu flag");
        zero_ev(); clr_cpu = 1'b1; in_sent = 8'h02; step();
        chk({7'd0, cpu_flag}, 8'h01, "R7 event beats cpu clear");
        zero_ev(); clr_cpu = 1'b1; step();
        chk({7'd0, cpu_flag}, 8'h00, "R7 cpu clear");
        zero_ev(); in_en = 8'h00; in_sent = 8'h02; step();
        chk({7'd0, cpu_flag}, 8'h00, "R6 masked event no cpu flag");

        // R8 global gate
        zero_ev(); in_en = 8'h02; glob_en = 1'b0; step();
        chk({7'd0, irq_req}, 8'h00, "R8 global disable");
        glob_en = 1'b1; #1;
        chk({7'd0, irq_req}, 8'h01, "R8 global enable");

        // Pseudo-random mix
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            logic [7:0] r0, r1, r2;
            zero_ev();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r0 = lfsr[7:0]; r1 = lfsr[15:8]; r2 = lfsr[7:0] ^ lfsr[15:8];
            in_sent   = r0 & r1;
            in_stall  = r1 & ~r2;
            in_flush  = r2 & r0 & 8'h55;
            out_rcvd  = r2 & ~r0;
            out_stall = r0 & 8'hAA;
            iso       = {r1[3:0], r2[3:0]};
            in_en     = r1 ^ 8'h3C;
            out_en    = r2;
            glob_en   = r0[3];
            clr_in    = (n % 3 == 0) ? ~r1 : 8'h00;
            clr_out   = (n % 4 == 0) ? r0 : 8'h00;
            clr_cpu   = r2[5];
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule